// File: doc/BRIEF.md
# Host Link Adapter Register Interface

This block connects an 8-bit host I/O bus to a byte-wide link adapter that serves a network of processors. Host software sees seven registers. Through them it can hand bytes to the outgoing link and collect bytes from the incoming link. It learns when each direction is ready by polling a status flag or by taking an interrupt. It also holds the network's active-low reset and analyse lines at chosen levels and reads back the shared error line.

The link side uses two simple byte handshakes. An incoming byte is taken while `rxValid` and `rxReady` are both high. An outgoing byte is offered on `txData` with `txValid` and is consumed while `txReady` is high. Read data on the host side is combinational: it is valid in the same cycle as `busRd`. The side effects of an access take place at the clock edge that ends that cycle.

Top module: `hostLinkRegs`

## Requirements
- R1: Register offsets are 0 input byte (read), 1 output byte (write), 2 receive status, 3 transmit status, 4 error flag (read), 5 reset control (write) and 6 analyse control (write). Reads of offsets 1, 5, 6 and 7 return 0x00.
- R2: When the input holding register is empty, `rxReady` is 1 and a byte with `rxValid` is captured. After that, bit 0 of the receive status reads 1 and `rxReady` is 0 until the byte is read.
- R3: A read of offset 0 returns the captured byte. After that read, receive status bit 0 reads 0 and `rxReady` returns to 1.
- R4: A write to offset 1 sets `txValid` with the written byte on `txData` and makes transmit status bit 0 read 0. Both stay that way until a cycle with `txReady` high, after which bit 0 reads 1 and `txValid` is 0.
- R5: A write to offset 1 while a byte is still pending is dropped, and `txData` keeps the pending byte.
- R6: Bit 1 of each status register is a read/write interrupt enable. Writing bit 0 of a status register has no effect. Both enables are 0 after reset.
- R7: `irq` is high exactly when (receive byte waiting AND receive enable) OR (transmit ready AND transmit enable).
- R8: Bit 0 of offset 4 reads 1 when `netErrN` is low and 0 when it is high. The other bits read 0.
- R9: Writing bit 0 = 1 to offset 5 drives `netResetN` low, and writing 0 drives it high. The level holds until the next write. After power-up reset, `netResetN` is low.
- R10: Writing bit 0 to offset 6 controls `netAnalyseN` in the same way as reset, independently of `netResetN`. After power-up reset, `netAnalyseN` is high.
- R11: Writes to offsets 0 and 4 change no state.
- R12: After power-up reset, transmit status reads 0x01, receive status reads 0x00, `irq` is 0 and `txValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| busAddr | input | 3 | Register offset |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Host read data, combinational |
| rxData | input | 8 | Byte from link |
| rxValid | input | 1 | Link byte present |
| rxReady | output | 1 | Block can accept a byte |
| txData | output | 8 | Byte to link |
| txValid | output | 1 | Byte pending for link |
| txReady | input | 1 | Link accepts the pending byte |
| netErrN | input | 1 | Wire-OR error line, active low |
| netResetN | output | 1 | Network reset, active low |
| netAnalyseN | output | 1 | Network analyse, active low |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the handshake edges. If a read of offset 0 did not clear the flag, `rxReady` would stay low and the link would stall. If a design overwrote the pending transmit byte, a different byte would appear on `txData` while `txValid` is still high. The bench also checks that writing status bit 0 does not forge a ready flag, and that an interrupt enable raises `irq` only while its flag is set. A design that tied analyse to reset, or that released reset at power-up, would show the wrong levels on the network lines.

// File: rtl/hlr_pkg.sv
package hlr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_IN_BYTE  = 3'd0,
    OFS_OUT_BYTE = 3'd1,
    OFS_RX_STAT  = 3'd2,
    OFS_TX_STAT  = 3'd3,
    OFS_ERR      = 3'd4,
    OFS_RST_CTL  = 3'd5,
    OFS_ANA_CTL  = 3'd6,
    OFS_SPARE    = 3'd7
  } regOfs_e;

  typedef struct packed {
    logic rdInByte;
    logic wrOutByte;
    logic wrRxStat;
    logic wrTxStat;
    logic wrRstCtl;
    logic wrAnaCtl;
  } hostStrobes_t;
endpackage

// File: rtl/hlr_ctrl.sv
module hlr_ctrl
  import hlr_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output hostStrobes_t      strobes,
  output regOfs_e           rdSel
);
  regOfs_e ofs;

  always_comb begin
    ofs = regOfs_e'(busAddr);
    rdSel = ofs;
    strobes = '0;
    strobes.rdInByte  = busRd && (ofs == OFS_IN_BYTE);
    if (busWr) begin
      unique case (ofs)
        OFS_OUT_BYTE: strobes.wrOutByte = 1'b1;
        OFS_RX_STAT:  strobes.wrRxStat  = 1'b1;
        OFS_TX_STAT:  strobes.wrTxStat  = 1'b1;
        OFS_RST_CTL:  strobes.wrRstCtl  = 1'b1;
        OFS_ANA_CTL:  strobes.wrAnaCtl  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hlr_datapath.sv
module hlr_datapath
  import hlr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  hostStrobes_t      strobes,
  input  regOfs_e           rdSel,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic              netErrN,
  output logic              netResetN,
  output logic              netAnalyseN,
  output logic              irq
);
  localparam int READY_BIT  = 0;
  localparam int ENABLE_BIT = 1;

  logic [DATA_W-1:0] inByte, outByte;
  logic inFull, outPending, rxIrqEn, txIrqEn, rstReq, anaReq;

  assign rxReady     = !inFull;
  assign txValid     = outPending;
  assign txData      = outByte;
  assign netResetN   = !rstReq;
  assign netAnalyseN = !anaReq;
  assign irq = (inFull && rxIrqEn) || (!outPending && txIrqEn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inByte <= '0;
      inFull <= 1'b0;
    end else if (rxValid && !inFull) begin
      inByte <= rxData;
      inFull <= 1'b1;
    end else if (strobes.rdInByte) begin
      inFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outByte    <= '0;
      outPending <= 1'b0;
    end else if (outPending) begin
      if (txReady) outPending <= 1'b0;
    end else if (strobes.wrOutByte) begin
      outByte    <= busWrData;
      outPending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxIrqEn <= 1'b0;
      txIrqEn <= 1'b0;
      rstReq  <= 1'b1;
      anaReq  <= 1'b0;
    end else begin
      if (strobes.wrRxStat) rxIrqEn <= busWrData[ENABLE_BIT];
      if (strobes.wrTxStat) txIrqEn <= busWrData[ENABLE_BIT];
      if (strobes.wrRstCtl) rstReq  <= busWrData[0];
      if (strobes.wrAnaCtl) anaReq  <= busWrData[0];
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (rdSel)
      OFS_IN_BYTE: busRdData = inByte;
      OFS_RX_STAT: begin
        busRdData[READY_BIT]  = inFull;
        busRdData[ENABLE_BIT] = rxIrqEn;
      end
      OFS_TX_STAT: begin
        busRdData[READY_BIT]  = !outPending;
        busRdData[ENABLE_BIT] = txIrqEn;
      end
      OFS_ERR: busRdData[0] = !netErrN;
      default: busRdData = '0;
    endcase
  end

  p_rx_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && rxReady) |=> (!rxReady && $stable(rxReady) == 1'b0 || !rxReady));
  p_rx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxReady && !strobes.rdInByte) |=> (!rxReady && $stable(inByte)));
  p_rd_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxReady && strobes.rdInByte) |=> rxReady);
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
  p_tx_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady) |=> !txValid);
  p_rst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.wrRstCtl |=> $stable(netResetN));
  p_ana_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.wrAnaCtl |=> $stable(netAnalyseN));
endmodule

// File: rtl/hostLinkRegs.sv
module hostLinkRegs
  import hlr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic              netErrN,
  output logic              netResetN,
  output logic              netAnalyseN,
  output logic              irq
);
  hostStrobes_t strobes;
  regOfs_e      rdSel;

  hlr_ctrl u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  hlr_datapath u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .rdSel       (rdSel),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .rxReady     (rxReady),
    .txData      (txData),
    .txValid     (txValid),
    .txReady     (txReady),
    .netErrN     (netErrN),
    .netResetN   (netResetN),
    .netAnalyseN (netAnalyseN),
    .irq         (irq)
  );
endmodule

// File: tb/hostLinkRegs_tb.sv
`timescale 1ns/1ps
module hostLinkRegs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWrData = '0, busRdData;
  logic [7:0] rxData = '0, txData;
  logic rxValid = 1'b0, rxReady, txValid, txReady = 1'b0;
  logic netErrN = 1'b1, netResetN, netAnalyseN, irq;

  int checks = 0, errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  hostLinkRegs u_dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data when a read is seen on the bus
  always @(negedge clk) begin
    if (busRd && rst_n) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read, actual %02h expected none", busRdData);
      end else begin
        check(tagQ.pop_front(), busRdData, expQ.pop_front());
      end
    end
  end

  task automatic hostRead(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    expQ.push_back(exp); tagQ.push_back(tag);
    busAddr = a; busRd = 1'b1;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic linkSend(input logic [7:0] d);
    logic ok;
    @(posedge clk); #1;
    rxData = d; rxValid = 1'b1;
    do begin
      @(negedge clk); ok = rxReady;
      @(posedge clk);
    end while (!ok);
    #1 rxValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 / R9 / R10 reset state
    check("R9 reset low at power-up", netResetN, 1'b0);
    check("R10 analyse high at power-up", netAnalyseN, 1'b1);
    check("R12 irq low", irq, 1'b0);
    check("R12 txValid low", txValid, 1'b0);
    check("R2 rxReady high when empty", rxReady, 1'b1);
    hostRead(3'd2, 8'h00, "R12 rx status");
    hostRead(3'd3, 8'h01, "R12 tx status");
    // R1 write-only reads
    hostRead(3'd1, 8'h00, "R1 out byte reads 0");
    hostRead(3'd5, 8'h00, "R1 reset ctl reads 0");
    hostRead(3'd6, 8'h00, "R1 analyse ctl reads 0");
    hostRead(3'd7, 8'h00, "R1 spare reads 0");
    // R8 error line
    hostRead(3'd4, 8'h00, "R8 no error");
    netErrN = 1'b0;
    hostRead(3'd4, 8'h01, "R8 error asserted");
    netErrN = 1'b1;
    // R9 / R10 control lines
    hostWrite(3'd5, 8'h00);
    check("R9 reset released", netResetN, 1'b1);
    hostWrite(3'd6, 8'h01);
    check("R10 analyse asserted", netAnalyseN, 1'b0);
    check("R10 reset unaffected", netResetN, 1'b1);
    repeat (4) @(posedge clk); #1;
    check("R9 reset level held", netResetN, 1'b1);
    hostWrite(3'd5, 8'h01);
    check("R9 reset reasserted", netResetN, 1'b0);
    check("R10 analyse unaffected", netAnalyseN, 1'b0);
    hostWrite(3'd6, 8'h00);
    hostWrite(3'd5, 8'h00);
    check("R10 analyse released", netAnalyseN, 1'b1);
    // R2 / R3 receive path
    linkSend(8'hA5);
    @(negedge clk);
    check("R2 rxReady low when full", rxReady, 1'b0);
    hostRead(3'd2, 8'h01, "R2 rx status full");
    hostRead(3'd0, 8'hA5, "R3 in byte");
    @(negedge clk);
    check("R3 rxReady after read", rxReady, 1'b1);
    hostRead(3'd2, 8'h00, "R3 rx status cleared");
    // R11 writes to read-only offsets
    hostWrite(3'd0, 8'hFF);
    hostWrite(3'd4, 8'hFF);
    hostRead(3'd2, 8'h00, "R11 rx status unchanged");
    hostRead(3'd0, 8'hA5, "R11 in byte unchanged");
    // R6 writing bit 0 of status is ignored
    hostWrite(3'd2, 8'h01);
    hostRead(3'd2, 8'h00, "R6 rx bit0 not writable");
    // R4 / R5 transmit path
    hostWrite(3'd1, 8'h5A);
    check("R4 txValid set", txValid, 1'b1);
    check("R4 txData", txData, 8'h5A);
    hostRead(3'd3, 8'h00, "R4 tx status pending");
    hostWrite(3'd1, 8'h77);
    check("R5 pending byte kept", txData, 8'h5A);
    check("R5 still valid", txValid, 1'b1);
    @(posedge clk); #1 txReady = 1'b1;
    @(posedge clk); #1 txReady = 1'b0;
    check("R4 txValid cleared", txValid, 1'b0);
    hostRead(3'd3, 8'h01, "R4 tx status ready");
    // R6 / R7 interrupts
    hostWrite(3'd3, 8'h02);
    check("R7 irq on tx ready", irq, 1'b1);
    hostRead(3'd3, 8'h03, "R6 tx enable readback");
    hostWrite(3'd3, 8'h00);
    check("R7 irq off when disabled", irq, 1'b0);
    hostWrite(3'd2, 8'h02);
    check("R7 irq off when rx empty", irq, 1'b0);
    hostRead(3'd2, 8'h02, "R6 rx enable readback");
    linkSend(8'h3C);
    @(negedge clk);
    check("R7 irq on rx byte", irq, 1'b1);
    hostRead(3'd0, 8'h3C, "R3 second byte");
    @(negedge clk);
    check("R7 irq off after read", irq, 1'b0);
    hostWrite(3'd3, 8'h02);
    hostWrite(3'd1, 8'hC3);
    check("R7 irq off while tx pending", irq, 1'b0);
    @(posedge clk); #1 txReady = 1'b1;
    @(posedge clk); #1 txReady = 1'b0;
    check("R7 irq back on after accept", irq, 1'b1);
    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule